// File: doc/BRIEF.md
# Instruction and Data Address Breakpoint Unit

This unit holds two breakpoint registers, one for instruction fetches and one for data accesses. It compares each fetch and each load or store address against them. Software loads the registers through a special-register write port that carries a register number. A register number of 1010 selects the instruction breakpoint register. A register number of 1013 selects the data breakpoint register. Any other number leaves both registers unchanged.

Each hit output is combinational from the current access and the registered breakpoint value. A match also needs the translation mode recorded in the breakpoint register to equal the matching machine-state translation bit. The fetch side uses the instruction-translation bit and the data side uses the data-translation bit. The instruction side matches on aligned words. The data side matches on aligned doublewords and has separate enables for reads and writes. What happens after a hit is left to the surrounding core.

Top module: `addr_bkpt_unit`

## Requirements
- R1: After reset both breakpoint registers hold zero, so neither hit output can assert.
- R2: A write with register number 1010 loads the instruction breakpoint register at the clock edge. The new value governs hits from the following cycle on, and the old value governs hits during the write cycle. Writes to any other register number leave this register unchanged.
- R3: A write with register number 1013 loads the data breakpoint register with the same timing as R2. Writes to any other register number leave this register unchanged.
- R4: An instruction hit needs fetch address bits [31:2] to equal instruction register bits [31:2]. Fetch address bits [1:0] are ignored.
- R5: Instruction register bit 1 enables instruction matching. When it is zero, no instruction hit occurs.
- R6: An instruction hit needs instruction register bit 0 to equal the machine-state instruction-translation input.
- R7: A data hit needs data address bits [31:3] to equal data register bits [31:3]. Data address bits [2:0] are ignored.
- R8: Data register bit 0 enables hits on reads (write-enable low). Data register bit 1 enables hits on writes (write-enable high).
- R9: A data hit needs data register bit 2 to equal the machine-state data-translation input.
- R10: Each hit output is low whenever its access-valid input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_we_i | input | 1 | Special-register write strobe |
| spr_num_i | input | 10 | Special-register number |
| spr_wdata_i | input | 32 | Special-register write data |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_addr_i | input | 32 | Fetch address |
| data_valid_i | input | 1 | Data access valid |
| data_we_i | input | 1 | Data access is a write |
| data_addr_i | input | 32 | Data access address |
| msr_ir_i | input | 1 | Machine-state instruction-translation bit |
| msr_dr_i | input | 1 | Machine-state data-translation bit |
| ibp_hit_o | output | 1 | Instruction breakpoint hit |
| dbp_hit_o | output | 1 | Data breakpoint hit |

## Verification
The assertions run on every cycle. They check the following:
- A write with a matching register number is taken on the next edge.
- A hit never occurs while its valid input is low.
- Every hit is consistent with the enable bit, the translation bit and the masked address in the register.

Several behaviours need the bench's scenarios:
- That low address bits are truly ignored.
- That a mismatch of any qualifier suppresses a hit.
- That the old register value still governs during the write cycle.
- That writes to other register numbers leave the stored value intact.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned IBP_IR_BIT = 0;
  localparam int unsigned IBP_EN_BIT = 1;
  localparam int unsigned IBP_LSB    = 2;
  localparam int unsigned DBP_RD_BIT = 0;
  localparam int unsigned DBP_WR_BIT = 1;
  localparam int unsigned DBP_DR_BIT = 2;
  localparam int unsigned DBP_LSB    = 3;
endpackage

// File: rtl/bkpt_spr_reg.sv
module bkpt_spr_reg #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NW     = 10,
  parameter int unsigned SPR_ID = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  localparam logic [NW-1:0] ID = NW'(SPR_ID);

  logic sel;
  assign sel = we_i && (num_i == ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= '0;
    else if (sel) q_o <= wdata_i;
  end

  // R2/R3: selected write lands on the next edge; others leave it alone
  p_write_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && num_i == ID) |=> (q_o == $past(wdata_i)));
  p_other_num_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && num_i == ID) |=> $stable(q_o));
endmodule

// File: rtl/bkpt_iaddr_cmp.sv
module bkpt_iaddr_cmp
  import bkpt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] bp_i,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          msr_ir_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] MASK = ~AW'((1 << IBP_LSB) - 1);

  logic addr_eq, mode_eq;
  assign addr_eq = ((addr_i ^ bp_i) & MASK) == '0;
  assign mode_eq = bp_i[IBP_IR_BIT] == msr_ir_i;
  assign hit_o   = valid_i && bp_i[IBP_EN_BIT] && addr_eq && mode_eq;
endmodule

// File: rtl/bkpt_daddr_cmp.sv
module bkpt_daddr_cmp
  import bkpt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] bp_i,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          msr_dr_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] MASK = ~AW'((1 << DBP_LSB) - 1);

  logic addr_eq, mode_eq, dir_en;
  assign addr_eq = ((addr_i ^ bp_i) & MASK) == '0;
  assign mode_eq = bp_i[DBP_DR_BIT] == msr_dr_i;
  assign dir_en  = we_i ? bp_i[DBP_WR_BIT] : bp_i[DBP_RD_BIT];
  assign hit_o   = valid_i && dir_en && addr_eq && mode_eq;
endmodule

// File: rtl/addr_bkpt_unit.sv
module addr_bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SPR_NW  = 10,
  parameter int unsigned IBP_NUM = 1010,
  parameter int unsigned DBP_NUM = 1013
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spr_we_i,
  input  logic [SPR_NW-1:0] spr_num_i,
  input  logic [ADDR_W-1:0] spr_wdata_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              data_valid_i,
  input  logic              data_we_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic              msr_ir_i,
  input  logic              msr_dr_i,
  output logic              ibp_hit_o,
  output logic              dbp_hit_o
);
  localparam int unsigned ID_I = IBP_NUM;
  localparam int unsigned ID_D = DBP_NUM;

  logic [ADDR_W-1:0] ibp_q, dbp_q;

  bkpt_spr_reg #(.DW(ADDR_W), .NW(SPR_NW), .SPR_ID(ID_I)) u_ibp_reg (
    .clk_i, .rst_ni, .we_i(spr_we_i), .num_i(spr_num_i),
    .wdata_i(spr_wdata_i), .q_o(ibp_q));

  bkpt_spr_reg #(.DW(ADDR_W), .NW(SPR_NW), .SPR_ID(ID_D)) u_dbp_reg (
    .clk_i, .rst_ni, .we_i(spr_we_i), .num_i(spr_num_i),
    .wdata_i(spr_wdata_i), .q_o(dbp_q));

  bkpt_iaddr_cmp #(.AW(ADDR_W)) u_icmp (
    .bp_i(ibp_q), .valid_i(fetch_valid_i), .addr_i(fetch_addr_i),
    .msr_ir_i, .hit_o(ibp_hit_o));

  bkpt_daddr_cmp #(.AW(ADDR_W)) u_dcmp (
    .bp_i(dbp_q), .valid_i(data_valid_i), .we_i(data_we_i),
    .addr_i(data_addr_i), .msr_dr_i, .hit_o(dbp_hit_o));

  p_ihit_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> !ibp_hit_o);
  p_dhit_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_i |-> !dbp_hit_o);
  p_ihit_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibp_hit_o |-> ibp_q[IBP_EN_BIT]);
  p_ihit_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibp_hit_o |-> (ibp_q[IBP_IR_BIT] == msr_ir_i));
  p_ihit_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibp_hit_o |-> (fetch_addr_i[ADDR_W-1:IBP_LSB] == ibp_q[ADDR_W-1:IBP_LSB]));
  p_dhit_dir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbp_hit_o |-> (data_we_i ? dbp_q[DBP_WR_BIT] : dbp_q[DBP_RD_BIT]));
  p_dhit_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbp_hit_o |-> (dbp_q[DBP_DR_BIT] == msr_dr_i));
  p_dhit_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbp_hit_o |-> (data_addr_i[ADDR_W-1:DBP_LSB] == dbp_q[ADDR_W-1:DBP_LSB]));
endmodule

// File: tb/sim_addr_bkpt_unit.sv
module sim_addr_bkpt_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic spr_we = 0;
  logic [9:0] spr_num = 0;
  logic [31:0] spr_wdata = 0;
  logic fv = 0, dv = 0, dwe = 0, ir = 0, dr = 0;
  logic [31:0] fa = 0, da = 0;
  logic ihit, dhit;
  int n_run = 0, n_fail = 0;
  logic [31:0] m_ibp = 0, m_dbp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_bkpt_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .spr_we_i(spr_we), .spr_num_i(spr_num),
    .spr_wdata_i(spr_wdata), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .data_valid_i(dv), .data_we_i(dwe), .data_addr_i(da),
    .msr_ir_i(ir), .msr_dr_i(dr), .ibp_hit_o(ihit), .dbp_hit_o(dhit));

  function automatic logic exp_i(logic [31:0] r, logic v, logic [31:0] a, logic m);
    return v && r[1] && (a[31:2] == r[31:2]) && (r[0] == m);
  endfunction

  function automatic logic exp_d(logic [31:0] r, logic v, logic w, logic [31:0] a, logic m);
    return v && (w ? r[1] : r[0]) && (a[31:3] == r[31:3]) && (r[2] == m);
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic spr_write(logic [9:0] n, logic [31:0] v);
    @(negedge clk);
    spr_we = 1; spr_num = n; spr_wdata = v;
    @(posedge clk); #1;
    spr_we = 0;
    if (n == 10'd1010) m_ibp = v;
    if (n == 10'd1013) m_dbp = v;
  endtask

  task automatic fetch(logic v, logic [31:0] a, logic m, string tag);
    fv = v; fa = a; ir = m; #1;
    chk(tag, ihit, exp_i(m_ibp, v, a, m));
  endtask

  task automatic dacc(logic v, logic w, logic [31:0] a, logic m, string tag);
    dv = v; dwe = w; da = a; dr = m; #1;
    chk(tag, dhit, exp_d(m_dbp, v, w, a, m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    // R1: reset state, zero registers never hit
    fetch(1, 32'h0, 0, "R1 ifetch");
    dacc(1, 0, 32'h0, 0, "R1 dread");
    dacc(1, 1, 32'h0, 0, "R1 dwrite");

    spr_write(10'd1010, 32'h0000_1002);
    fetch(1, 32'h0000_1000, 0, "R2 loaded");
    fetch(1, 32'h0000_1003, 0, "R4 low bits ignored");
    fetch(1, 32'h0000_1004, 0, "R4 next word");
    fetch(1, 32'h0000_1000, 1, "R6 ir mismatch");
    fetch(0, 32'h0000_1000, 0, "R10 fetch invalid");
    spr_write(10'd1011, 32'h0);
    fetch(1, 32'h0000_1000, 0, "R2 other num ignored");
    // R2: old value still in force during the write cycle
    @(negedge clk);
    spr_we = 1; spr_num = 10'd1010; spr_wdata = 32'h0000_1000;
    fa = 32'h0000_1000; fv = 1; ir = 0; #1;
    chk("R2 old value in write cycle", ihit, 1'b1);
    @(posedge clk); #1;
    spr_we = 0; m_ibp = 32'h0000_1000;
    fetch(1, 32'h0000_1000, 0, "R5 disabled");
    spr_write(10'd1010, 32'h8000_0003);
    fetch(1, 32'h8000_0001, 1, "R6 ir match");

    spr_write(10'd1013, 32'h0000_2001);
    dacc(1, 0, 32'h0000_2007, 0, "R7 low bits ignored");
    dacc(1, 0, 32'h0000_2008, 0, "R7 next dword");
    dacc(1, 1, 32'h0000_2000, 0, "R8 write not enabled");
    spr_write(10'd1012, 32'hFFFF_FFFF);
    dacc(1, 0, 32'h0000_2000, 0, "R3 other num ignored");
    spr_write(10'd1013, 32'h0000_2006);
    dacc(1, 1, 32'h0000_2004, 1, "R9 dr match");
    dacc(1, 1, 32'h0000_2004, 0, "R9 dr mismatch");
    dacc(1, 0, 32'h0000_2004, 1, "R8 read not enabled");
    dacc(0, 1, 32'h0000_2004, 1, "R10 data invalid");

    // random mix, addresses often near the breakpoints
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [9:0] n;
        n = ($urandom_range(0, 1) != 0) ? 10'd1010 : 10'd1013;
        if ($urandom_range(0, 3) == 0) n = 10'($urandom_range(1008, 1015));
        spr_write(n, $urandom());
      end
      fetch($urandom_range(0, 3) != 0,
            ($urandom_range(0, 1) != 0) ? (m_ibp ^ 32'($urandom_range(0, 7))) : $urandom(),
            1'($urandom_range(0, 1)), "R4 R5 R6 random");
      dacc($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 1) != 0) ? (m_dbp ^ 32'($urandom_range(0, 15))) : $urandom(),
           1'($urandom_range(0, 1)), "R7 R8 R9 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule